// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block decides when a processor core stops for debug and how it starts again. Four halt requests arrive, each with a fixed rank: a fault-on-fault indication, a hardware-breakpoint trigger, a decoded HALT instruction qualified by the current privilege mode, and an external breakpoint pin. The fault and the HALT instruction act in the cycle they appear. The two breakpoint requests are only remembered as pending. They take effect at the next per-instruction sample strobe. The external breakpoint also takes effect at once while the core sits in the stopped state.

After reset is released, the core waits a fixed number of cycles before it starts reset exception processing. An external breakpoint seen early in that wait parks the core in a special post-reset halt. Only during that halt may the emulation-mode control bit be written. A GO command from the debug serial interface ends any halt. The block then reports one of three resume targets. These are the next sequential instruction, the PC that the debugger loaded, or the normal reset exception sequence. All control and status pins are plain levels or single-cycle strobes. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: When several halt causes are present in the same cycle, `halt_src_o` records only the strongest. The ranking from strongest down is fault-on-fault (code 4'h8), hardware breakpoint (4'h4), HALT instruction (4'h2) and external breakpoint (4'h1). The field is 4'h0 while not halted.
- R2: While running, `fault_i` high at a clock edge halts the core at that edge, with no sample strobe needed.
- R3: A pulse on `hwbp_i` or `bkpt_i` while running does not halt the core. It is held pending, and the core halts at the first edge where `sample_i` is high.
- R4: `halt_insn_i` halts the core at that edge unless `user_mode_i` is 1 and `uhe_i` is 0. In that case `priv_viol_o` is high in the same cycle and no halt follows. With `uhe_i` at 1, the HALT instruction also halts in user mode.
- R5: `halted_o` is 1 while halted and 0 otherwise. `pst_o` is 4'hF while halted and 4'h0 otherwise, and both read 0 in reset.
- R6: After reset release, `rst_exc_o` pulses for one cycle after the WAIT_CYC-th clock edge (16th by default) unless the core was captured first. `bkpt_i` high at any of the first CAPTURE_CYC edges (8 by default) halts the core with source 4'h1. A breakpoint seen later in the wait only becomes pending.
- R7: `emu_we_o` follows `emu_wr_i` only during the post-reset halt. At all other times it is 0.
- R8: A GO that ends the post-reset halt sets `resume_sel_o` to 2'b01 (debugger PC) if `pc_loaded_i` is 1. Otherwise it sets 2'b10 (reset exception processing).
- R9: With `stopped_i` at 1, `bkpt_i` halts the core at that edge without a sample strobe. The following GO sets `resume_sel_o` to 2'b00 (next sequential instruction).
- R10: A GO while halted for any cause other than the post-reset capture leaves the halt one edge later. It pulses `resume_o` for one cycle, sets `resume_sel_o` to 2'b00 and clears `halt_src_o`.
- R11: A GO while not halted has no effect. `resume_o` stays 0 and `halted_o` is unchanged.
- R12: Entering a halt clears both pending breakpoint flags, so one breakpoint pulse causes at most one halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Fault-on-fault indication |
| hwbp_i | input | 1 | Hardware breakpoint trigger |
| halt_insn_i | input | 1 | Decoded HALT instruction executing |
| user_mode_i | input | 1 | Core is in user mode |
| uhe_i | input | 1 | User-halt-enable control bit |
| bkpt_i | input | 1 | External breakpoint pin |
| sample_i | input | 1 | Per-instruction halt/interrupt sample strobe |
| stopped_i | input | 1 | Core is stopped by a STOP instruction |
| go_i | input | 1 | GO command strobe from the serial interface |
| pc_loaded_i | input | 1 | Debugger wrote the PC during this halt |
| emu_wr_i | input | 1 | Request to write the emulation-mode bit |
| halted_o | output | 1 | Core is in the debug halted state |
| pst_o | output | 4 | Processor status code |
| halt_src_o | output | 4 | One-hot halt source |
| priv_viol_o | output | 1 | Privilege-violation request for a user-mode HALT |
| emu_we_o | output | 1 | Emulation-mode bit write enable |
| resume_sel_o | output | 2 | Resume target chosen at the last GO |
| resume_o | output | 1 | One-cycle pulse when a GO is accepted |
| rst_exc_o | output | 1 | One-cycle pulse starting reset exception processing |

## Verification
The bench builds the block with WAIT_CYC = 16 and CAPTURE_CYC = 8. With these values the whole reset wait lasts only sixteen edges, so it can be replayed from reset in every scenario that needs it. Both sides of the capture boundary, the eighth and the ninth edge, can then be hit exactly. The ninth-edge case also shows that a late breakpoint survives the wait as a pending request and fires at the first sample strobe once the core runs.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } halt_state_e;

  localparam logic [3:0] SRC_NONE  = 4'h0;
  localparam logic [3:0] SRC_FAULT = 4'h8;
  localparam logic [3:0] SRC_HWBP  = 4'h4;
  localparam logic [3:0] SRC_INSN  = 4'h2;
  localparam logic [3:0] SRC_EXT   = 4'h1;

  localparam logic [3:0] PST_RUN   = 4'h0;
  localparam logic [3:0] PST_HALT  = 4'hF;

  localparam logic [1:0] RES_NEXT  = 2'b00;
  localparam logic [1:0] RES_PC    = 2'b01;
  localparam logic [1:0] RES_RESET = 2'b10;

endpackage

// File: rtl/dbg_halt_boot_timer.sv
module dbg_halt_boot_timer #(
  parameter int WAIT_CYC    = 16,
  parameter int CAPTURE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic in_capture,
  output logic at_last
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(CAPTURE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_capture = (cnt_q < CNT_CAP);
  assign at_last    = (cnt_q == CNT_LAST);
endmodule

// File: rtl/dbg_halt_pending.sv
module dbg_halt_pending #(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            clr,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] eff_o
);
  logic [NREQ-1:0] pend_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (clr) begin
        pend_q[g] <= 1'b0;
      end else if (arm && req_i[g]) begin
        pend_q[g] <= 1'b1;
      end
    end
    assign eff_o[g] = pend_q[g] | (arm & req_i[g]);
  end
endmodule

// File: rtl/dbg_halt_arbiter.sv
module dbg_halt_arbiter #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] cand_i,
  output logic            any_o,
  output logic [NSRC-1:0] win_o
);
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i]) begin
        win_o = '0;
        win_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |cand_i;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int WAIT_CYC    = 16,
  parameter int CAPTURE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_i,
  input  logic       hwbp_i,
  input  logic       halt_insn_i,
  input  logic       user_mode_i,
  input  logic       uhe_i,
  input  logic       bkpt_i,
  input  logic       sample_i,
  input  logic       stopped_i,
  input  logic       go_i,
  input  logic       pc_loaded_i,
  input  logic       emu_wr_i,
  output logic       halted_o,
  output logic [3:0] pst_o,
  output logic [3:0] halt_src_o,
  output logic       priv_viol_o,
  output logic       emu_we_o,
  output logic [1:0] resume_sel_o,
  output logic       resume_o,
  output logic       rst_exc_o
);
  halt_state_e st_q;
  logic [3:0]  src_q;
  logic        por_q;
  logic        resume_q;
  logic [1:0]  sel_q;
  logic        rexc_q;

  logic        in_run;
  logic        in_boot;
  logic        in_capture;
  logic        at_last;
  logic [1:0]  pend_eff;
  logic [3:0]  cand;
  logic [3:0]  win;
  logic        halt_now;
  logic        por_hit;
  logic        insn_ok;

  assign in_run  = (st_q == ST_RUN);
  assign in_boot = (st_q == ST_BOOT);

  dbg_halt_boot_timer #(
    .WAIT_CYC   (WAIT_CYC),
    .CAPTURE_CYC(CAPTURE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_capture(in_capture),
    .at_last   (at_last)
  );

  assign por_hit = in_boot & bkpt_i & in_capture;

  // bit 1: hardware breakpoint, bit 0: external breakpoint
  dbg_halt_pending #(.NREQ(2)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (in_run | in_boot),
    .clr  (halt_now | por_hit),
    .req_i({hwbp_i, bkpt_i}),
    .eff_o(pend_eff)
  );

  assign insn_ok     = halt_insn_i & ~(user_mode_i & ~uhe_i);
  assign priv_viol_o = in_run & halt_insn_i & user_mode_i & ~uhe_i;

  assign cand[3] = in_run & fault_i;
  assign cand[2] = in_run & sample_i & pend_eff[1];
  assign cand[1] = in_run & insn_ok;
  assign cand[0] = in_run & (sample_i | stopped_i) & pend_eff[0];

  dbg_halt_arbiter #(.NSRC(4)) u_arb (
    .cand_i(cand),
    .any_o (halt_now),
    .win_o (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_BOOT;
      src_q    <= SRC_NONE;
      por_q    <= 1'b0;
      resume_q <= 1'b0;
      sel_q    <= RES_NEXT;
      rexc_q   <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      rexc_q   <= 1'b0;
      unique case (st_q)
        ST_BOOT: begin
          if (por_hit) begin
            st_q  <= ST_HALT;
            src_q <= SRC_EXT;
            por_q <= 1'b1;
          end else if (at_last) begin
            st_q   <= ST_RUN;
            rexc_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (halt_now) begin
            st_q  <= ST_HALT;
            src_q <= win;
          end
        end
        ST_HALT: begin
          if (go_i) begin
            st_q     <= ST_RUN;
            src_q    <= SRC_NONE;
            por_q    <= 1'b0;
            resume_q <= 1'b1;
            if (por_q) begin
              sel_q <= pc_loaded_i ? RES_PC : RES_RESET;
            end else begin
              sel_q <= RES_NEXT;
            end
          end
        end
        default: st_q <= ST_BOOT;
      endcase
    end
  end

  assign halted_o     = (st_q == ST_HALT);
  assign pst_o        = halted_o ? PST_HALT : PST_RUN;
  assign halt_src_o   = src_q;
  assign emu_we_o     = emu_wr_i & halted_o & por_q;
  assign resume_sel_o = sel_q;
  assign resume_o     = resume_q;
  assign rst_exc_o    = rexc_q;
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_run,
  input logic       fault_i,
  input logic       hwbp_i,
  input logic       halt_insn_i,
  input logic       user_mode_i,
  input logic       uhe_i,
  input logic       sample_i,
  input logic       stopped_i,
  input logic       go_i,
  input logic       halted_o,
  input logic [3:0] halt_src_o,
  input logic       emu_we_o,
  input logic       resume_o,
  input logic       rst_exc_o
);
  // R1: at most one source bit recorded
  a_r1_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(halt_src_o));

  // R2: fault halts on the same edge with top-rank source
  a_r2_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && fault_i |=> halted_o && halt_src_o == 4'h8);

  // R3: without a sample strobe, stop state or immediate cause, no halt
  a_r3_wait_sample: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && !sample_i && !stopped_i && !fault_i && !halt_insn_i |=> !halted_o);

  // R4: user-mode HALT without permission does not halt
  a_r4_priv_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && halt_insn_i && user_mode_i && !uhe_i && !fault_i && !sample_i && !stopped_i
    |=> !halted_o);

  // R7: emulation write enable only while halted
  a_r7_emu_halted: assert property (@(posedge clk) disable iff (!rst_n)
    emu_we_o |-> halted_o);

  // R10: GO leaves the halt and clears the source
  a_r10_go_resume: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o && go_i |=> !halted_o && resume_o && halt_src_o == 4'h0);

  // R11: GO while not halted is ignored
  a_r11_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_o && go_i |=> !resume_o);

  // R6: reset processing never starts from a halt
  a_r6_rexc_running: assert property (@(posedge clk) disable iff (!rst_n)
    rst_exc_o |-> !halted_o);
endmodule

bind dbg_halt_ctrl dbg_halt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_run     (in_run),
  .fault_i    (fault_i),
  .hwbp_i     (hwbp_i),
  .halt_insn_i(halt_insn_i),
  .user_mode_i(user_mode_i),
  .uhe_i      (uhe_i),
  .sample_i   (sample_i),
  .stopped_i  (stopped_i),
  .go_i       (go_i),
  .halted_o   (halted_o),
  .halt_src_o (halt_src_o),
  .emu_we_o   (emu_we_o),
  .resume_o   (resume_o),
  .rst_exc_o  (rst_exc_o)
);

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_i = 0, hwbp_i = 0, halt_insn_i = 0, user_mode_i = 0, uhe_i = 0;
  logic bkpt_i = 0, sample_i = 0, stopped_i = 0, go_i = 0, pc_loaded_i = 0, emu_wr_i = 0;
  logic       halted_o;
  logic [3:0] pst_o;
  logic [3:0] halt_src_o;
  logic       priv_viol_o;
  logic       emu_we_o;
  logic [1:0] resume_sel_o;
  logic       resume_o;
  logic       rst_exc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.WAIT_CYC(16), .CAPTURE_CYC(8)) dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .hwbp_i(hwbp_i),
    .halt_insn_i(halt_insn_i), .user_mode_i(user_mode_i), .uhe_i(uhe_i),
    .bkpt_i(bkpt_i), .sample_i(sample_i), .stopped_i(stopped_i), .go_i(go_i),
    .pc_loaded_i(pc_loaded_i), .emu_wr_i(emu_wr_i), .halted_o(halted_o),
    .pst_o(pst_o), .halt_src_o(halt_src_o), .priv_viol_o(priv_viol_o),
    .emu_we_o(emu_we_o), .resume_sel_o(resume_sel_o), .resume_o(resume_o),
    .rst_exc_o(rst_exc_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    fault_i = 0; hwbp_i = 0; halt_insn_i = 0; user_mode_i = 0; uhe_i = 0;
    bkpt_i = 0; sample_i = 0; stopped_i = 0; go_i = 0; pc_loaded_i = 0; emu_wr_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 0;
    tick(2);
    rst_n = 1;
  endtask

  task automatic boot_run();
    do_reset();
    tick(16);
  endtask

  task automatic do_go(input logic pcl);
    go_i = 1; pc_loaded_i = pcl;
    tick(1);
    go_i = 0; pc_loaded_i = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    clear_in();
    rst_n = 0;
    tick(1);
    check("R5 halted in reset", {7'd0, halted_o}, 8'd0);
    check("R5 pst in reset", {4'd0, pst_o}, 8'h0);
    check("R1 src in reset", {4'd0, halt_src_o}, 8'h0);
  endtask

  task automatic t_boot_capture();
    do_reset();
    tick(7);
    bkpt_i = 1;
    tick(1);
    bkpt_i = 0;
    check("R6 capture on 8th edge", {7'd0, halted_o}, 8'd1);
    check("R5 pst halted", {4'd0, pst_o}, 8'hF);
    check("R6 capture src", {4'd0, halt_src_o}, 8'h1);
    emu_wr_i = 1; #1;
    check("R7 emu we in post-reset halt", {7'd0, emu_we_o}, 8'd1);
    emu_wr_i = 0;
    do_go(1'b1);
    check("R8 resume pulse", {7'd0, resume_o}, 8'd1);
    check("R8 resume to PC", {6'd0, resume_sel_o}, 8'h1);
    check("R10 src cleared", {4'd0, halt_src_o}, 8'h0);
    emu_wr_i = 1; #1;
    check("R7 emu we after go", {7'd0, emu_we_o}, 8'd0);
    emu_wr_i = 0;
    tick(16);
    check("R6 no reset exc after capture", {7'd0, rst_exc_o}, 8'd0);
  endtask

  task automatic t_boot_nopc();
    do_reset();
    bkpt_i = 1;
    tick(1);
    bkpt_i = 0;
    check("R6 capture on 1st edge", {7'd0, halted_o}, 8'd1);
    do_go(1'b0);
    check("R8 resume to reset exc", {6'd0, resume_sel_o}, 8'h2);
  endtask

  task automatic t_boot_late();
    do_reset();
    tick(8);
    bkpt_i = 1;
    tick(1);
    bkpt_i = 0;
    check("R6 no capture on 9th edge", {7'd0, halted_o}, 8'd0);
    tick(6);
    check("R6 reset exc not yet", {7'd0, rst_exc_o}, 8'd0);
    tick(1);
    check("R6 reset exc pulse", {7'd0, rst_exc_o}, 8'd1);
    tick(1);
    check("R6 reset exc single", {7'd0, rst_exc_o}, 8'd0);
    check("R3 late bkpt pending only", {7'd0, halted_o}, 8'd0);
    sample_i = 1;
    tick(1);
    sample_i = 0;
    check("R3 pending bkpt at sample", {7'd0, halted_o}, 8'd1);
    check("R3 pending bkpt src", {4'd0, halt_src_o}, 8'h1);
    do_go(1'b1);
    check("R10 resume next insn", {6'd0, resume_sel_o}, 8'h0);
  endtask

  task automatic t_fault();
    boot_run();
    tick(1);
    fault_i = 1;
    tick(1);
    fault_i = 0;
    check("R2 fault halts at once", {7'd0, halted_o}, 8'd1);
    check("R2 fault src", {4'd0, halt_src_o}, 8'h8);
    emu_wr_i = 1; #1;
    check("R7 no emu we in normal halt", {7'd0, emu_we_o}, 8'd0);
    emu_wr_i = 0;
    go_i = 1; tick(1); go_i = 0;
    check("R10 go leaves halt", {7'd0, halted_o}, 8'd0);
    check("R10 resume pulse", {7'd0, resume_o}, 8'd1);
    tick(1);
    check("R10 resume pulse single", {7'd0, resume_o}, 8'd0);
  endtask

  task automatic t_pending_once();
    boot_run();
    hwbp_i = 1; tick(1); hwbp_i = 0;
    tick(3);
    check("R3 hw bp waits for sample", {7'd0, halted_o}, 8'd0);
    sample_i = 1; tick(1); sample_i = 0;
    check("R3 hw bp halts at sample", {7'd0, halted_o}, 8'd1);
    check("R3 hw bp src", {4'd0, halt_src_o}, 8'h4);
    do_go(1'b0);
    sample_i = 1; tick(1); sample_i = 0;
    check("R12 one pulse one halt", {7'd0, halted_o}, 8'd0);
  endtask

  task automatic t_priority();
    boot_run();
    fault_i = 1; hwbp_i = 1; halt_insn_i = 1; bkpt_i = 1; sample_i = 1;
    tick(1);
    clear_in();
    check("R1 fault wins", {4'd0, halt_src_o}, 8'h8);
    do_go(1'b0);
    hwbp_i = 1; halt_insn_i = 1; sample_i = 1; bkpt_i = 1;
    tick(1);
    clear_in();
    check("R1 hw bp over insn", {4'd0, halt_src_o}, 8'h4);
    do_go(1'b0);
    halt_insn_i = 1; bkpt_i = 1; sample_i = 1;
    tick(1);
    clear_in();
    check("R1 insn over ext bp", {4'd0, halt_src_o}, 8'h2);
    do_go(1'b0);
    sample_i = 1; tick(1); sample_i = 0;
    check("R12 ext bp cleared by halt", {7'd0, halted_o}, 8'd0);
  endtask

  task automatic t_priv();
    boot_run();
    halt_insn_i = 1; user_mode_i = 1; uhe_i = 0; #1;
    check("R4 priv violation", {7'd0, priv_viol_o}, 8'd1);
    tick(1);
    halt_insn_i = 0;
    check("R4 no halt without uhe", {7'd0, halted_o}, 8'd0);
    uhe_i = 1; halt_insn_i = 1; #1;
    check("R4 no violation with uhe", {7'd0, priv_viol_o}, 8'd0);
    tick(1);
    clear_in();
    check("R4 user halt with uhe", {7'd0, halted_o}, 8'd1);
    check("R4 insn src", {4'd0, halt_src_o}, 8'h2);
    do_go(1'b0);
  endtask

  task automatic t_stop();
    boot_run();
    stopped_i = 1; bkpt_i = 1;
    tick(1);
    bkpt_i = 0; stopped_i = 0;
    check("R9 stop + bkpt halts", {7'd0, halted_o}, 8'd1);
    check("R9 src ext", {4'd0, halt_src_o}, 8'h1);
    do_go(1'b1);
    check("R9 resume next insn", {6'd0, resume_sel_o}, 8'h0);
    check("R9 resume pulse", {7'd0, resume_o}, 8'd1);
  endtask

  task automatic t_go_idle();
    boot_run();
    tick(1);
    go_i = 1; tick(1); go_i = 0;
    check("R11 go ignored resume", {7'd0, resume_o}, 8'd0);
    check("R11 go ignored halted", {7'd0, halted_o}, 8'd0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_boot_capture();
        t_boot_nopc();
        t_boot_late();
        t_fault();
        t_pending_once();
        t_priority();
        t_priv();
        t_stop();
        t_go_idle();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule